// File: doc/BRIEF.md
# Chained Packet Readout Merger

This block sits at the end of a front-end chip's readout path, in a chain of identical chips that hand packets along one serial line. It gathers fixed-length packets from three local producers (fast-readout clusters, full-readout clusters and register readback) and from the neighbour chip upstream. It frames each local packet with a start bit, a type code, the chip's identity and a stop bit, and sends everything out one bit per clock toward the next chip. Packets that come from upstream are deserialised into a pass-through queue and sent on without change.

Each source has its own small queue. When a packet ends, a fixed priority picks the next queue to send: fast readout first, then full readout, then register readback, then pass-through. A packet always finishes once its first bit has gone out. Downstream back-pressure is a plain level, `dn_xoff`. It is only looked at when a packet is about to start, so while it is high no new packet begins. The block in turn raises `up_xoff` toward the upstream chip before its pass-through queue could overflow.

The three local inputs are valid/ready streams. A word is taken on a clock edge where both `*_valid` and `*_ready` are high. Ready is high whenever that source's queue has a free entry and does not depend on valid. A producer must hold its valid and data steady until the word is taken. The serial links have no handshake. The line idles at 0 between packets, and the only back-pressure is the xoff pair.

Top module: `pkt_chain_merge`

## Requirements
- R1: Every packet on `dn_bit` is 59 bits long and sent most significant bit first, one bit per clock. The bits, from first to last, are: a start bit of 1, the 4-bit type, the 4-bit chip ID, the 49-bit payload, and a stop bit of 1. Between packets the line is 0.
- R2: Local packets carry type 0010 (fast readout), 0110 (full readout) or 1000 (register readback), together with the current `chip_id`. A pass-through packet is sent again bit for bit, keeping its own type and chip ID.
- R3: The payload of a register-readback packet is, from its most significant bit down: the error flag `reg_seu`, the 8-bit `reg_addr`, the 32-bit `reg_value`, and then eight 0 bits.
- R4: When a packet starts, the source chosen is the highest-priority non-empty queue. The order is fast readout, full readout, register readback, then pass-through. Packets from the same source keep their arrival order.
- R5: A packet that has started always sends all 59 bits. When further packets are waiting and `dn_xoff` is low, the next start bit follows the previous stop bit with no idle cycle.
- R6: `dn_xoff` is sampled only when a packet could start. While it is high, no packet starts. A packet already in progress when it rises still completes.
- R7: Each local queue holds 4 packets. `*_ready` goes low when the queue is full, and a word offered then is not taken. The three queues fill independently.
- R8: The upstream receiver starts a packet on the first 1 it sees on an idle `up_bit` and takes the 58 bits that follow. A packet whose final (stop) bit is 0 is discarded. The receiver is then ready for the next start bit at once.
- R9: `up_xoff` is high when the pass-through queue entries, plus any packet being received or waiting to be written, reach 4. The upstream chip honouring this means no upstream packet is ever lost.
- R10: While in reset, `dn_bit` is 0, all three `*_ready` are 1 and `up_xoff` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_id | input | 4 | Identity written into local packets |
| fast_valid | input | 1 | Fast-readout word offered |
| fast_ready | output | 1 | Fast-readout queue has room |
| fast_data | input | 49 | Fast-readout payload |
| full_valid | input | 1 | Full-readout word offered |
| full_ready | output | 1 | Full-readout queue has room |
| full_data | input | 49 | Full-readout payload |
| reg_valid | input | 1 | Register readback offered |
| reg_ready | output | 1 | Register queue has room |
| reg_seu | input | 1 | Upset flag for the register read |
| reg_addr | input | 8 | Register address |
| reg_value | input | 32 | Register contents |
| up_bit | input | 1 | Serial packets from the upstream chip |
| up_xoff | output | 1 | Stop request to the upstream chip |
| dn_bit | output | 1 | Serial packets toward the downstream chip |
| dn_xoff | input | 1 | Stop request from the downstream chip |

## Verification
The bench loads every non-empty subset of the four queues while downstream is stopped, then releases it. It checks that packets leave in priority order and exactly 59 cycles apart: a merger with a wrong priority chain reorders them, and one that idles after each packet shows a gap. It raises `dn_xoff` partway through a packet. A design that looked at the stop level mid-packet would truncate that packet, and one that ignored the level would send the queued packet anyway. It also fills a local queue one word past its depth, and sends an upstream packet with a bad stop bit followed by a good one. A receiver that lost framing would drop or corrupt the good packet. Finally it fills the pass-through queue so that an early or late `up_xoff` shows as a wrong level or a lost packet.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam int TYPE_W = 4;
  localparam int ID_W   = 4;

  localparam logic [TYPE_W-1:0] TYPE_FAST = 4'b0010;
  localparam logic [TYPE_W-1:0] TYPE_FULL = 4'b0110;
  localparam logic [TYPE_W-1:0] TYPE_REG  = 4'b1000;

  // queue index doubles as priority rank (0 is served first)
  localparam int SRC_FAST = 0;
  localparam int SRC_FULL = 1;
  localparam int SRC_REG  = 2;
  localparam int SRC_PASS = 3;
  localparam int NSRC     = 4;
endpackage

// File: rtl/chain_fifo.sv
module chain_fifo #(
  parameter int W     = 58,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          is_full, is_empty;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full  = (cnt == CW'(DEPTH));
  assign is_empty = (cnt == '0);
  assign dout     = mem[rp];
  assign count    = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !is_full); // R7
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !is_empty); // R4
endmodule

// File: rtl/chain_rx.sv
module chain_rx #(
  parameter int BODY_W = 58
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  output logic              word_valid,
  output logic [BODY_W-1:0] word,
  output logic              busy
);
  localparam int CNT_W = $clog2(BODY_W + 1);

  logic              act;
  logic [CNT_W-1:0]  left;
  logic [BODY_W-2:0] hist;
  logic              pend_v;
  logic [BODY_W-1:0] pend_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= 1'b0;
      left   <= '0;
      hist   <= '0;
      pend_v <= 1'b0;
      pend_d <= '0;
    end else begin
      pend_v <= 1'b0;
      if (!act) begin
        if (rx_bit) begin
          act  <= 1'b1;
          left <= CNT_W'(BODY_W);
        end
      end else begin
        hist <= {hist[BODY_W-3:0], rx_bit};
        left <= left - 1'b1;
        if (left == CNT_W'(1)) begin
          act    <= 1'b0;
          pend_v <= rx_bit;              // stop bit must be 1
          pend_d <= {hist, rx_bit};
        end
      end
    end
  end

  assign word_valid = pend_v;
  assign word       = pend_d;
  assign busy       = act;

  AST_RX_STOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word[0]); // R8
  AST_RX_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    act && (left == CNT_W'(1)) |=> !act); // R8
endmodule

// File: rtl/chain_tx.sv
module chain_tx #(
  parameter int NSRC   = 4,
  parameter int BODY_W = 58
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSRC-1:0]              req,
  input  logic [NSRC-1:0][BODY_W-1:0]  body,
  input  logic                         xoff,
  output logic [NSRC-1:0]              grant,
  output logic                         ser_out
);
  localparam int FRAME_W = BODY_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic               busy;
  logic [CNT_W-1:0]   left;
  logic [FRAME_W-1:0] shreg;
  logic [NSRC-1:0]    pick;
  logic [BODY_W-1:0]  sel_body;
  logic               boundary, start;

  // lowest index wins: scan from the bottom of the ranking upward
  always_comb begin
    pick     = '0;
    sel_body = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
        sel_body = body[i];
      end
    end
  end

  assign boundary = !busy || (left == '0);
  assign start    = boundary && !xoff && (|req);
  assign grant    = start ? pick : '0;
  assign ser_out  = busy & shreg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      left  <= '0;
      shreg <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      left  <= CNT_W'(FRAME_W - 1);
      shreg <= {1'b1, sel_body};
    end else if (busy) begin
      shreg <= shreg << 1;
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end
  end

  AST_TX_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4
  AST_TX_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ser_out); // R1
  AST_TX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_out); // R1
  AST_TX_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (left != '0) |=> busy && (left == $past(left) - 1'b1)); // R5
  AST_TX_XOFF_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    xoff && boundary |=> !busy); // R6
endmodule

// File: rtl/pkt_chain_merge.sv
module pkt_chain_merge
  import chain_pkg::*;
#(
  parameter int PAY_W      = 49,
  parameter int LDEPTH     = 4,
  parameter int TDEPTH     = 4,
  parameter int REG_ADDR_W = 8,
  parameter int REG_VAL_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ID_W-1:0]       chip_id,
  input  logic                  fast_valid,
  output logic                  fast_ready,
  input  logic [PAY_W-1:0]      fast_data,
  input  logic                  full_valid,
  output logic                  full_ready,
  input  logic [PAY_W-1:0]      full_data,
  input  logic                  reg_valid,
  output logic                  reg_ready,
  input  logic                  reg_seu,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [REG_VAL_W-1:0]  reg_value,
  input  logic                  up_bit,
  output logic                  up_xoff,
  output logic                  dn_bit,
  input  logic                  dn_xoff
);
  localparam int BODY_W = TYPE_W + ID_W + PAY_W + 1;
  localparam int PAD_W  = PAY_W - 1 - REG_ADDR_W - REG_VAL_W;
  localparam int MAXD   = (LDEPTH > TDEPTH) ? LDEPTH : TDEPTH;
  localparam int CW     = $clog2(MAXD + 1);

  logic [NSRC-1:0][BODY_W-1:0] in_body;
  logic [NSRC-1:0][BODY_W-1:0] q_body;
  logic [NSRC-1:0][CW-1:0]     q_lvl;
  logic [NSRC-1:0]             in_valid, q_push, q_full, q_req, q_pop;
  logic                        rx_valid, rx_busy;
  logic [BODY_W-1:0]           rx_word;
  logic [PAY_W-1:0]            reg_payload;

  assign reg_payload = {reg_seu, reg_addr, reg_value, {PAD_W{1'b0}}};

  assign in_body[SRC_FAST] = {TYPE_FAST, chip_id, fast_data, 1'b1};
  assign in_body[SRC_FULL] = {TYPE_FULL, chip_id, full_data, 1'b1};
  assign in_body[SRC_REG]  = {TYPE_REG,  chip_id, reg_payload, 1'b1};
  assign in_body[SRC_PASS] = rx_word;

  assign in_valid[SRC_FAST] = fast_valid;
  assign in_valid[SRC_FULL] = full_valid;
  assign in_valid[SRC_REG]  = reg_valid;
  assign in_valid[SRC_PASS] = rx_valid;

  chain_rx #(.BODY_W(BODY_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_bit(up_bit),
    .word_valid(rx_valid), .word(rx_word), .busy(rx_busy)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_q
    localparam int DG = (g == SRC_PASS) ? TDEPTH : LDEPTH;
    assign q_full[g] = (q_lvl[g] == CW'(DG));
    assign q_req[g]  = (q_lvl[g] != '0);
    assign q_push[g] = in_valid[g] && !q_full[g];
    chain_fifo #(.W(BODY_W), .DEPTH(DG), .CW(CW)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(q_push[g]), .din(in_body[g]),
      .pop(q_pop[g]), .dout(q_body[g]), .count(q_lvl[g])
    );
  end

  assign fast_ready = !q_full[SRC_FAST];
  assign full_ready = !q_full[SRC_FULL];
  assign reg_ready  = !q_full[SRC_REG];

  // count the packet being received and the one waiting to be written
  assign up_xoff = (int'(q_lvl[SRC_PASS]) + int'(rx_valid) + int'(rx_busy)) >= TDEPTH;

  chain_tx #(.NSRC(NSRC), .BODY_W(BODY_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .req(q_req), .body(q_body),
    .xoff(dn_xoff), .grant(q_pop), .ser_out(dn_bit)
  );

  AST_PASS_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !q_full[SRC_PASS]); // R9
  AST_XOFF_BEFORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    q_full[SRC_PASS] |-> up_xoff); // R9
endmodule

// File: tb/pkt_chain_merge_bench.sv
module pkt_chain_merge_bench;
  localparam int PW = 49;
  localparam int FW = 59;
  localparam int LD = 4;
  localparam int TD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] chip_id = 4'h0;
  logic fast_valid = 1'b0, full_valid = 1'b0, reg_valid = 1'b0;
  logic fast_ready, full_ready, reg_ready;
  logic [PW-1:0] fast_data = '0, full_data = '0;
  logic reg_seu = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_value = '0;
  logic up_bit = 1'b0, up_xoff, dn_bit, dn_xoff = 1'b0;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  logic [FW-1:0] cap_q[$];
  int cap_t[$];
  logic [FW-1:0] exp_f [8];
  logic m_act = 1'b0;
  logic [FW-1:0] m_sh;
  int m_n = 0, m_start = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pkt_chain_merge u_pkt_chain_merge (
    .clk(clk), .rst_n(rst_n), .chip_id(chip_id),
    .fast_valid(fast_valid), .fast_ready(fast_ready), .fast_data(fast_data),
    .full_valid(full_valid), .full_ready(full_ready), .full_data(full_data),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_seu(reg_seu),
    .reg_addr(reg_addr), .reg_value(reg_value),
    .up_bit(up_bit), .up_xoff(up_xoff), .dn_bit(dn_bit), .dn_xoff(dn_xoff)
  );

  // downstream receiver model
  always @(negedge clk) begin
    if (!rst_n) m_act = 1'b0;
    else if (!m_act) begin
      if (dn_bit) begin
        m_act = 1'b1; m_sh = {{(FW-1){1'b0}}, 1'b1}; m_n = 1; m_start = cyc;
      end
    end else begin
      m_sh = {m_sh[FW-2:0], dn_bit};
      m_n++;
      if (m_n == FW) begin
        cap_q.push_back(m_sh); cap_t.push_back(m_start); m_act = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  function automatic logic [3:0] tcode(input int s);
    return (s == 0) ? 4'b0010 : (s == 1) ? 4'b0110 : 4'b1000;
  endfunction

  function automatic logic [FW-1:0] mkf(input logic [3:0] t, input logic [3:0] id, input logic [PW-1:0] pl);
    return {1'b1, t, id, pl, 1'b1};
  endfunction

  function automatic logic ready_of(input int s);
    return (s == 0) ? fast_ready : (s == 1) ? full_ready : reg_ready;
  endfunction

  // returns the payload the frame must carry
  task automatic push_src(input int s, input logic [PW-1:0] pl, input logic seu,
                          input logic [7:0] a, input logic [31:0] v, output logic [PW-1:0] sent);
    @(negedge clk);
    if (s == 0) begin fast_data = pl; fast_valid = 1'b1; sent = pl; end
    else if (s == 1) begin full_data = pl; full_valid = 1'b1; sent = pl; end
    else begin
      reg_seu = seu; reg_addr = a; reg_value = v; reg_valid = 1'b1;
      sent = {seu, a, v, 8'h00};
    end
    while (!ready_of(s)) @(negedge clk);
    @(negedge clk);
    fast_valid = 1'b0; full_valid = 1'b0; reg_valid = 1'b0;
  endtask

  task automatic feed_up(input logic [FW-2:0] b);
    @(negedge clk);
    while (up_xoff) @(negedge clk);
    up_bit = 1'b1;
    for (int i = FW - 2; i >= 0; i--) begin
      @(negedge clk); up_bit = b[i];
    end
    @(negedge clk); up_bit = 1'b0;
  endtask

  task automatic expect_frames(input int n, input bit contig, input string tag);
    int w = 0;
    while (cap_q.size() < n && w < n * FW + 300) begin @(negedge clk); w++; end
    repeat (70) @(negedge clk);
    chk(cap_q.size() == n, tag, 64'(cap_q.size()), 64'(n));
    for (int i = 0; i < n; i++) begin
      if (i < cap_q.size()) begin
        chk(cap_q[i] == exp_f[i], tag, 64'(cap_q[i]), 64'(exp_f[i]));
        if (contig && i > 0)
          chk(cap_t[i] - cap_t[i-1] == FW, "R5", 64'(cap_t[i] - cap_t[i-1]), 64'(FW));
      end
    end
    cap_q.delete(); cap_t.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] sent;
    logic [PW-1:0] pl;
    logic [FW-2:0] b;
    int n;
    int acc;
    logic a;

    // reset state R10
    repeat (5) @(negedge clk);
    chk(dn_bit == 1'b0, "R10", 64'(dn_bit), 64'd0);
    chk(fast_ready && full_ready && reg_ready, "R10",
        64'({fast_ready, full_ready, reg_ready}), 64'h7);
    chk(up_xoff == 1'b0, "R10", 64'(up_xoff), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // single packets, payload patterns: R1 R2 R3
    for (int p = 0; p < 6; p++) begin
      pl = (p == 0) ? '0 : (p == 1) ? '1 : (p == 2) ? {25{2'b01}} : (PW'(1) << (p * 8));
      for (int s = 0; s < 3; s++) begin
        chip_id = 4'(p * 3 + s);
        push_src(s, pl, p[0], 8'(p * 37 + 5), 32'hDEAD_0000 + 32'(p), sent);
        exp_f[0] = mkf(tcode(s), 4'(p * 3 + s), sent);
        expect_frames(1, 1'b0, (s == 2) ? "R3" : "R1");
      end
      b = {4'b0011, 4'(15 - p), pl ^ PW'(p), 1'b1};
      feed_up(b);
      exp_f[0] = {1'b1, b};
      expect_frames(1, 1'b0, "R2");
    end

    // priority sweep over all source subsets: R4 R5
    chip_id = 4'hA;
    for (int m = 1; m < 16; m++) begin
      @(negedge clk); dn_xoff = 1'b1;
      n = 0;
      for (int s = 0; s < 3; s++) begin
        if (m[s]) begin
          push_src(s, PW'(m * 16 + s), m[1], 8'(m), 32'(m * 1000 + s), sent);
          exp_f[n] = mkf(tcode(s), 4'hA, sent); n++;
        end
      end
      if (m[3]) begin
        b = {4'b0011, 4'h9, PW'(m), 1'b1};
        feed_up(b);
        exp_f[n] = {1'b1, b}; n++;
      end
      repeat (4) @(negedge clk);
      dn_xoff = 1'b0;
      expect_frames(n, 1'b1, "R4");
    end

    // xoff raised mid-packet: R6
    @(negedge clk); dn_xoff = 1'b0;
    push_src(0, PW'(49'h1_2345), 1'b0, 8'h0, 32'h0, sent);
    exp_f[0] = mkf(4'b0010, 4'hA, sent);
    push_src(0, PW'(49'h6_789A), 1'b0, 8'h0, 32'h0, sent);
    repeat (20) @(negedge clk);
    dn_xoff = 1'b1;
    repeat (150) @(negedge clk);
    chk(cap_q.size() == 1, "R6", 64'(cap_q.size()), 64'd1);
    if (cap_q.size() > 0) chk(cap_q[0] == exp_f[0], "R6", 64'(cap_q[0]), 64'(exp_f[0]));
    cap_q.delete(); cap_t.delete();
    exp_f[0] = mkf(4'b0010, 4'hA, sent);
    dn_xoff = 1'b0;
    expect_frames(1, 1'b0, "R6");

    // local queue fill: R7
    @(negedge clk); dn_xoff = 1'b1;
    acc = 0;
    for (int i = 0; i < LD + 1; i++) begin
      @(negedge clk);
      fast_data = PW'(100 + i); fast_valid = 1'b1; a = fast_ready;
      if (a) begin exp_f[acc] = mkf(4'b0010, 4'hA, PW'(100 + i)); acc++; end
    end
    @(negedge clk); fast_valid = 1'b0;
    chk(acc == LD, "R7", 64'(acc), 64'(LD));
    chk(fast_ready == 1'b0, "R7", 64'(fast_ready), 64'd0);
    chk(full_ready == 1'b1 && reg_ready == 1'b1, "R7", 64'({full_ready, reg_ready}), 64'h3);
    dn_xoff = 1'b0;
    expect_frames(LD, 1'b1, "R7");

    // bad stop bit upstream, then recovery: R8
    feed_up({4'b0011, 4'h5, PW'(49'h123), 1'b0});
    repeat (200) @(negedge clk);
    chk(cap_q.size() == 0, "R8", 64'(cap_q.size()), 64'd0);
    b = {4'b0011, 4'h5, PW'(49'h456), 1'b1};
    feed_up(b);
    exp_f[0] = {1'b1, b};
    expect_frames(1, 1'b0, "R8");

    // pass-through back-pressure: R9
    @(negedge clk); dn_xoff = 1'b1;
    for (int k = 0; k < TD; k++) begin
      chk(up_xoff == 1'b0, "R9", 64'(up_xoff), 64'd0);
      b = {4'b0011, 4'(k), PW'(k * 7 + 1), 1'b1};
      feed_up(b);
      exp_f[k] = {1'b1, b};
      repeat (3) @(negedge clk);
    end
    chk(up_xoff == 1'b1, "R9", 64'(up_xoff), 64'd1);
    dn_xoff = 1'b0;
    expect_frames(TD, 1'b1, "R9");
    chk(up_xoff == 1'b0, "R9", 64'(up_xoff), 64'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule